// File: doc/BRIEF.md
# Condition Code Gate with Status Flags

This block decides, for each instruction word presented to it, whether that instruction is allowed to take effect. It reads a four-bit condition selector from the most significant nibble of the word. It tests that selector against four stored status flags: negative, zero, carry and overflow. It then drives an execute-or-skip decision in the same cycle.

The same block owns the status flags. When an instruction executes and asks to change the flags, the new values from the arithmetic unit are loaded at the next rising clock edge. Comparison operations and flag-setting data operations both use this one request input, so the block does not need to know which kind of operation is running.

The selector value 1111 is reserved. The block flags it on a separate output and never lets such an instruction execute. Arithmetic and full instruction decoding are left to neighbouring logic.

Top module: `cond_gate`

## Requirements
- R1: The condition selector is bits 31 down to 28 of `instr_i`; bits 27 down to 0 have no effect on `exec_o` or `bad_cond_o`.
- R2: Selectors 0000 to 0111 test one flag each: 0000 Z=1, 0001 Z=0, 0010 C=1, 0011 C=0, 0100 N=1, 0101 N=0, 0110 V=1, 0111 V=0; `exec_o` is 1 exactly when the test holds.
- R3: Selector 1000 executes when C=1 and Z=0; selector 1001 executes when C=0 or Z=1.
- R4: Selector 1010 executes when N equals V; selector 1011 executes when N differs from V.
- R5: Selector 1100 executes when Z=0 and N equals V; selector 1101 executes when Z=1 or N differs from V.
- R6: Selector 1110 always executes, whatever the flags.
- R7: Selector 1111 drives `bad_cond_o` to 1 and `exec_o` to 0; for every other selector `bad_cond_o` is 0.
- R8: When `exec_o` and `set_flags_i` are both 1 at a rising clock edge, the flags take the value of `alu_flags_i` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V). The new values govern `exec_o` from the next cycle, and the old values govern the current cycle.
- R9: With `set_flags_i` at 0, the flags keep their values across a clock edge.
- R10: A skipped instruction, including a reserved selector, leaves the flags unchanged even when `set_flags_i` is 1.
- R11: A synchronous active-high `rst` clears all four flags to 0.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word; top nibble is the condition selector |
| set_flags_i | input | 1 | Request to load the flags if the instruction executes |
| alu_flags_i | input | 4 | New flag values {N,Z,C,V} |
| exec_o | output | 1 | 1 = instruction executes, 0 = skipped |
| bad_cond_o | output | 1 | Reserved selector 1111 seen |

## Verification
The bench sweeps all sixteen selectors against all sixteen flag combinations and changes the low instruction bits as it goes. A selector decoded from the wrong nibble, or a swapped signed and unsigned pair, would therefore show up as a wrong `exec_o`.

It writes the flags with a selector that executes under the old flags but not under the new ones. A design that checks against the flags being written, and not the stored ones, would give the wrong decision in that cycle.

Separate scenarios request an update on a skipped instruction, on the reserved selector, and with the request low. A design that loads the flags regardless of the decision would then change later decisions.

// File: rtl/cond_pkg.sv
package cond_pkg;

  localparam int unsigned SEL_W  = 4;
  localparam int unsigned FLAG_N = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_ZS   = 4'b0000,
    SEL_ZC   = 4'b0001,
    SEL_CS   = 4'b0010,
    SEL_CC   = 4'b0011,
    SEL_NS   = 4'b0100,
    SEL_NC   = 4'b0101,
    SEL_VS   = 4'b0110,
    SEL_VC   = 4'b0111,
    SEL_UGT  = 4'b1000,
    SEL_ULE  = 4'b1001,
    SEL_SGE  = 4'b1010,
    SEL_SLT  = 4'b1011,
    SEL_SGT  = 4'b1100,
    SEL_SLE  = 4'b1101,
    SEL_ALL  = 4'b1110,
    SEL_RSV  = 4'b1111
  } sel_e;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
  import cond_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  flags_t           flags_i,
  output logic             pass_o,
  output logic             rsv_o
);

  logic sign_eq;
  assign sign_eq = (flags_i.n == flags_i.v);

  always_comb begin
    pass_o = 1'b0;
    rsv_o  = 1'b0;
    unique case (sel_e'(sel_i))
      SEL_ZS:  pass_o =  flags_i.z;
      SEL_ZC:  pass_o = ~flags_i.z;
      SEL_CS:  pass_o =  flags_i.c;
      SEL_CC:  pass_o = ~flags_i.c;
      SEL_NS:  pass_o =  flags_i.n;
      SEL_NC:  pass_o = ~flags_i.n;
      SEL_VS:  pass_o =  flags_i.v;
      SEL_VC:  pass_o = ~flags_i.v;
      SEL_UGT: pass_o =  flags_i.c & ~flags_i.z;
      SEL_ULE: pass_o = ~flags_i.c |  flags_i.z;
      SEL_SGE: pass_o =  sign_eq;
      SEL_SLT: pass_o = ~sign_eq;
      SEL_SGT: pass_o = ~flags_i.z &  sign_eq;
      SEL_SLE: pass_o =  flags_i.z | ~sign_eq;
      SEL_ALL: pass_o = 1'b1;
      SEL_RSV: rsv_o  = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/flag_reg.sv
module flag_reg #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        q_o[i] <= 1'b0;
      else if (load_i)
        q_o[i] <= d_i[i];
    end
  end

endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cond_pkg::*;
#(
  parameter int unsigned INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               set_flags_i,
  input  logic [FLAG_N-1:0]  alu_flags_i,
  output logic               exec_o,
  output logic               bad_cond_o
);

  localparam int unsigned SEL_MSB = INSTR_W - 1;

  logic [SEL_W-1:0]  sel;
  logic [FLAG_N-1:0] flags_q;
  flags_t            flags_s;
  logic              pass;
  logic              rsv;
  logic              load;

  assign sel     = instr_i[SEL_MSB -: SEL_W];
  assign flags_s = flags_t'(flags_q);

  cond_eval u_eval (
    .sel_i   (sel),
    .flags_i (flags_s),
    .pass_o  (pass),
    .rsv_o   (rsv)
  );

  assign exec_o     = pass & ~rsv;
  assign bad_cond_o = rsv;
  assign load       = exec_o & set_flags_i;

  flag_reg #(.WIDTH(FLAG_N)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .d_i    (alu_flags_i),
    .q_o    (flags_q)
  );

endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr_i,
  input logic        set_flags_i,
  input logic [3:0]  alu_flags_i,
  input logic        exec_o,
  input logic        bad_cond_o,
  input logic [3:0]  flags_q
);

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> flags_q == 4'b0000); // R11

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (exec_o && set_flags_i) |=> flags_q == $past(alu_flags_i)); // R8

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(exec_o && set_flags_i) |=> $stable(flags_q)); // R10

  AST_NO_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !set_flags_i |=> $stable(flags_q)); // R9

  AST_RSV_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (instr_i[31:28] == 4'b1111) |-> (bad_cond_o && !exec_o)); // R7

  AST_RSV_ONLY: assert property (@(posedge clk) disable iff (rst)
    (instr_i[31:28] != 4'b1111) |-> !bad_cond_o); // R7

  AST_ALWAYS_RUN: assert property (@(posedge clk) disable iff (rst)
    (instr_i[31:28] == 4'b1110) |-> exec_o); // R6

  AST_SGT_RUN: assert property (@(posedge clk) disable iff (rst)
    (instr_i[31:28] == 4'b1100 && !flags_q[2] && flags_q[3] == flags_q[0]) |-> exec_o); // R5

endmodule

bind cond_gate cond_gate_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .instr_i     (instr_i),
  .set_flags_i (set_flags_i),
  .alu_flags_i (alu_flags_i),
  .exec_o      (exec_o),
  .bad_cond_o  (bad_cond_o),
  .flags_q     (flags_q)
);

// File: tb/cond_gate_tb.sv
module cond_gate_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'h0;
  logic        set_flags = 1'b0;
  logic [3:0]  alu_flags = 4'h0;
  logic        exec;
  logic        bad_cond;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_gate dut_i (
    .clk         (clk),
    .rst         (rst),
    .instr_i     (instr),
    .set_flags_i (set_flags),
    .alu_flags_i (alu_flags),
    .exec_o      (exec),
    .bad_cond_o  (bad_cond)
  );

  // expected decision from the requirement table; f = {N,Z,C,V}
  function automatic logic model(input logic [3:0] s, input logic [3:0] f);
    logic n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (s)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return c;
      4'h3: return !c;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return c && !z;
      4'h9: return !c || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, then settle
  task automatic drive(input logic [3:0] s, input logic [27:0] low,
                       input logic upd, input logic [3:0] nf);
    @(negedge clk);
    instr     = {s, low};
    set_flags = upd;
    alu_flags = nf;
    #1;
  endtask

  task automatic write_flags(input logic [3:0] nf);
    drive(4'hE, 28'h0, 1'b1, nf);
    @(posedge clk);
    drive(4'hE, 28'h0, 1'b0, 4'h0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 16; s++) begin
      drive(4'(s), 28'h0, 1'b0, 4'h0);
      check("R11 reset flags zero", exec, model(4'(s), 4'h0));
    end
  endtask

  task automatic t_sweep;
    for (int f = 0; f < 16; f++) begin
      write_flags(4'(f));
      for (int s = 0; s < 16; s++) begin
        logic [27:0] low;
        low = 28'h5A3C96F ^ 28'(f * 28'h0111111 + s * 28'h1234567);
        drive(4'(s), low, 1'b0, 4'h0);
        if (s < 8)       check("R2 single flag", exec, model(4'(s), 4'(f)));
        else if (s < 10) check("R3 unsigned pair", exec, model(4'(s), 4'(f)));
        else if (s < 12) check("R4 sign compare", exec, model(4'(s), 4'(f)));
        else if (s < 14) check("R5 signed gt/le", exec, model(4'(s), 4'(f)));
        else if (s == 14) check("R6 always", exec, 1'b1);
        else              check("R7 reserved no exec", exec, 1'b0);
        check("R7 reserved flag", bad_cond, s == 15);
        drive(4'(s), ~low, 1'b0, 4'h0);
        check("R1 low bits ignored", exec, model(4'(s), 4'(f)));
      end
    end
  endtask

  task automatic t_next_cycle;
    write_flags(4'h0);
    drive(4'h1, 28'h0, 1'b1, 4'b0100);
    check("R8 old flags this cycle", exec, 1'b1);
    @(posedge clk);
    #1;
    check("R8 new flags next cycle", exec, 1'b0);
    drive(4'h0, 28'h0, 1'b0, 4'h0);
    check("R8 Z loaded at bit 2", exec, 1'b1);
  endtask

  task automatic t_skip_hold;
    write_flags(4'b0100);
    drive(4'h1, 28'h0, 1'b1, 4'b1011);
    check("R10 skipped", exec, 1'b0);
    @(posedge clk);
    drive(4'h0, 28'h0, 1'b0, 4'h0);
    check("R10 Z kept after skip", exec, 1'b1);
    drive(4'h4, 28'h0, 1'b0, 4'h0);
    check("R10 N not loaded after skip", exec, 1'b0);
  endtask

  task automatic t_reserved_hold;
    write_flags(4'h0);
    drive(4'hF, 28'hFFFFFFF, 1'b1, 4'hF);
    @(posedge clk);
    drive(4'h4, 28'h0, 1'b0, 4'h0);
    check("R10 reserved no load N", exec, 1'b0);
    drive(4'h6, 28'h0, 1'b0, 4'h0);
    check("R10 reserved no load V", exec, 1'b0);
  endtask

  task automatic t_no_request;
    write_flags(4'h0);
    drive(4'hE, 28'h0, 1'b0, 4'hF);
    @(posedge clk);
    drive(4'h2, 28'h0, 1'b0, 4'h0);
    check("R9 no request C kept", exec, 1'b0);
    drive(4'h4, 28'h0, 1'b0, 4'h0);
    check("R9 no request N kept", exec, 1'b0);
  endtask

  task automatic t_reset_again;
    write_flags(4'hF);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    drive(4'h0, 28'h0, 1'b0, 4'h0);
    check("R11 reset clears Z", exec, 1'b0);
    drive(4'h2, 28'h0, 1'b0, 4'h0);
    check("R11 reset clears C", exec, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset;
    t_sweep;
    t_next_cycle;
    t_skip_hold;
    t_reserved_hold;
    t_no_request;
    t_reset_again;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule